// File: doc/BRIEF.md
# Down-Counting Interval Timer

This block is a bus-attached countdown timer. Software writes one register that holds a start count and a mode flag. While the external run-enable input is high, the count drops by one on every clock. When the count reaches the end, the block raises a one-clock expiry pulse. In one-shot mode it then parks at zero. In reload mode it restarts from the last value written and keeps running. The run-enable input is held low whenever the processor is stopped for debug, so the timer freezes together with the processor.

The same logic serves as a watchdog when its expiry pulse drives a reset line instead of an interrupt line. For that use the block is built with the reload option removed. The mode flag is then dropped on write, and the unit always behaves as a one-shot.

The register port is a single-word slave. A strobe with write-enable either loads the register or samples it for a read, and an acknowledge follows one clock later. The port never applies back-pressure: the stall output is always low, so every strobe is accepted in the cycle it is presented.

Top module: `dnt_interval_timer`

## Requirements
- R1: After reset the count, the stored reload value and the mode flag are all zero, and the expiry, acknowledge and read-data outputs are all zero.
- R2: Every strobe is acknowledged exactly one clock after it is presented, and only then; the stall output is always low.
- R3: A write loads bits [30:0] of the write data as both the count and the reload value, and loads bit 31 as the mode flag (1 = reload, 0 = one-shot). A read returns {mode flag, count} as they stood in the strobe cycle.
- R4: With a nonzero count and no write, the count drops by one on each clock where run-enable is high, and it holds its value while run-enable is low.
- R5: In one-shot mode, the clock edge that takes the count from 1 to 0 also raises the expiry output for exactly one cycle. The count then stays at zero.
- R6: In reload mode, the clock edge at which the count would reach zero loads the reload value instead and pulses the expiry output. With a reload value of N and run-enable held high, a pulse therefore occurs every N cycles.
- R7: Writing zero leaves the timer idle, and it raises no expiry pulse however long run-enable stays high.
- R8: A write in the same cycle as a count step takes precedence, even when the count is at 1. No expiry pulse results from that cycle.
- R9: When built without the reload option (RELOAD_EN = 0), bit 31 of a write is ignored. Such a unit reads back with bit 31 clear and stops at zero after a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Counting allowed while high; low during a debug halt |
| reg_stb | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_wdata | input | DATA_W | Write data: [31] mode flag, [30:0] count |
| reg_ack | output | 1 | Acknowledge, one clock after the strobe |
| reg_stall | output | 1 | Always low |
| reg_rdata | output | DATA_W | {mode flag, count} sampled at the strobe |
| expire_irq | output | 1 | One-clock expiry pulse, routed to an interrupt or to a reset |

## Verification
A corrupted count becomes visible at the very next read, one clock after the strobe. It also moves the expiry pulse off its computed cycle, so a single off-by-one step is caught at the first expiry. A wrong reload value or a wrong mode flag shows up by the second period of a reload run, as a wrong pulse spacing, a missing pulse or an extra pulse. A read taken just after the expiry also exposes a one-shot timer that fails to park at zero, or a reload timer that fails to restart. Because writes and count steps can collide, the bench also writes at a count of 1 and checks that no pulse escapes.

// File: rtl/dnt_pkg.sv
package dnt_pkg;
  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_RELOAD  = 1'b1
  } dnt_mode_e;
endpackage

// File: rtl/dnt_bus_port.sv
module dnt_bus_port #(
  parameter int DATA_W = 32,
  localparam int CNT_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              live_mode,
  output logic              wr_en,
  output logic [CNT_W-1:0]  wr_count,
  output logic              wr_mode,
  output logic              ack,
  output logic              stall,
  output logic [DATA_W-1:0] rdata
);
  assign wr_en    = stb && we;
  assign wr_count = wdata[CNT_W-1:0];
  assign wr_mode  = wdata[DATA_W-1];
  assign stall    = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= stb;
      if (stb && !we) rdata <= {live_mode, live_cnt};
    end
  end
endmodule

// File: rtl/dnt_counter.sv
module dnt_counter #(
  parameter int CNT_W     = 31,
  parameter bit RELOAD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             wr_mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic             mode_q,
  output logic             hit
);
  import dnt_pkg::*;

  logic [CNT_W-1:0] reload_q;
  logic             mode_eff;

  generate
    if (RELOAD_EN) begin : g_reload
      assign mode_eff = wr_mode;
    end else begin : g_oneshot_only
      assign mode_eff = MODE_ONESHOT;
    end
  endgenerate

  assign hit = run_en && !wr_en && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
      mode_q   <= MODE_ONESHOT;
    end else if (wr_en) begin
      cnt_q    <= wr_count;
      reload_q <= wr_count;
      mode_q   <= mode_eff;
    end else if (hit) begin
      cnt_q <= (mode_q == MODE_RELOAD) ? reload_q : '0;
    end else if (run_en && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dnt_irq_gen.sv
module dnt_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= hit;
  end
endmodule

// File: rtl/dnt_interval_timer.sv
module dnt_interval_timer #(
  parameter int DATA_W    = 32,
  parameter bit RELOAD_EN = 1'b1,
  localparam int CNT_W    = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              reg_stb,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              reg_ack,
  output logic              reg_stall,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              expire_irq
);
  logic             wr_en;
  logic [CNT_W-1:0] wr_count;
  logic             wr_mode;
  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;
  logic             hit;

  dnt_bus_port #(.DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .stb(reg_stb), .we(reg_we), .wdata(reg_wdata),
    .live_cnt(cnt_q), .live_mode(mode_q),
    .wr_en(wr_en), .wr_count(wr_count), .wr_mode(wr_mode),
    .ack(reg_ack), .stall(reg_stall), .rdata(reg_rdata)
  );

  dnt_counter #(.CNT_W(CNT_W), .RELOAD_EN(RELOAD_EN)) u_cnt (
    .clk(clk), .rst(rst), .run_en(run_en),
    .wr_en(wr_en), .wr_count(wr_count), .wr_mode(wr_mode),
    .cnt_q(cnt_q), .mode_q(mode_q), .hit(hit)
  );

  dnt_irq_gen u_irq (.clk(clk), .rst(rst), .hit(hit), .irq(expire_irq));
endmodule

// File: rtl/dnt_timer_chk.sv
module dnt_timer_chk #(
  parameter int CNT_W     = 31,
  parameter bit RELOAD_EN = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             reg_stb,
  input logic             reg_we,
  input logic             reg_ack,
  input logic             reg_stall,
  input logic             expire_irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic             mode_q
);
  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (rst)
    reg_stb |=> reg_ack);
  assert_no_stray_ack_R2: assert property (@(posedge clk) disable iff (rst)
    !reg_stb |=> !reg_ack);
  assert_never_stall_R2: assert property (@(posedge clk) disable iff (rst)
    !reg_stall);
  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !(reg_stb && reg_we)) |=> $stable(cnt_q));
  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (run_en && !(reg_stb && reg_we) && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  assert_oneshot_parks_R5: assert property (@(posedge clk) disable iff (rst)
    (expire_irq && !mode_q) |-> cnt_q == '0);
  assert_oneshot_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (expire_irq && !mode_q) |=> !expire_irq);
  assert_write_no_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_stb && reg_we) |=> !expire_irq);
  assert_mode_dropped_R9: assert property (@(posedge clk) disable iff (rst)
    !RELOAD_EN |-> !mode_q);
endmodule

bind dnt_interval_timer dnt_timer_chk #(.CNT_W(CNT_W), .RELOAD_EN(RELOAD_EN)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .reg_stb(reg_stb), .reg_we(reg_we),
  .reg_ack(reg_ack), .reg_stall(reg_stall), .expire_irq(expire_irq),
  .cnt_q(cnt_q), .mode_q(mode_q)
);

// File: tb/dnt_interval_timer_tb.sv
module dnt_interval_timer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic stb_a = 1'b0, stb_b = 1'b0, we = 1'b0;
  logic [31:0] wdata = '0;
  logic ack_a, ack_b, stall_a, stall_b, irq_a, irq_b;
  logic [31:0] rdata_a, rdata_b;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic stb_a_q = 1'b0, stb_b_q = 1'b0, we_q = 1'b0;

  always #2.5 clk = ~clk;

  dnt_interval_timer u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .reg_stb(stb_a), .reg_we(we),
    .reg_wdata(wdata), .reg_ack(ack_a), .reg_stall(stall_a),
    .reg_rdata(rdata_a), .expire_irq(irq_a));

  dnt_interval_timer #(.RELOAD_EN(1'b0)) u_wdt (
    .clk(clk), .rst(rst), .run_en(run_en), .reg_stb(stb_b), .reg_we(we),
    .reg_wdata(wdata), .reg_ack(ack_b), .reg_stall(stall_b),
    .reg_rdata(rdata_b), .expire_irq(irq_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    stb_a_q <= stb_a;
    stb_b_q <= stb_b;
    we_q    <= we;
  end

  // monitor: acknowledge timing and scoreboard of read results
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 ack timing dut", {31'b0, ack_a}, {31'b0, stb_a_q});
      chk("R2 ack timing wdt", {31'b0, ack_b}, {31'b0, stb_b_q});
      chk("R2 stall low", {30'b0, stall_a, stall_b}, 32'h0);
      if ((ack_a || ack_b) && !we_q) begin
        if (exp_q.size() == 0) chk("R3 unexpected read", 32'h1, 32'h0);
        else chk(tag_q.pop_front(), ack_a ? rdata_a : rdata_b, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input bit sel, input logic [31:0] v);
    @(negedge clk);
    if (sel) stb_b = 1'b1; else stb_a = 1'b1;
    we = 1'b1; wdata = v;
    @(negedge clk);
    stb_a = 1'b0; stb_b = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input bit sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    if (sel) stb_b = 1'b1; else stb_a = 1'b1;
    we = 1'b0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    stb_a = 1'b0; stb_b = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_for(input bit sel, input int k, output int pulses, output int first);
    pulses = 0; first = 0;
    @(negedge clk);
    run_en = 1'b1;
    for (int i = 1; i <= k; i++) begin
      @(negedge clk);
      if (sel ? irq_b : irq_a) begin
        pulses++;
        if (first == 0) first = i;
      end
      if (i == k) run_en = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int p, f;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'b0, irq_a, ack_a, irq_b, ack_b}, 32'h0);
    chk("R1 reset rdata", rdata_a | rdata_b, 32'h0);
    rst = 1'b0;
    rd(1'b0, 32'h0, "R1 count and mode cleared");

    // R3 load and R4 hold / step
    wr(1'b0, 32'h0000_0010);
    repeat (5) @(negedge clk);
    rd(1'b0, 32'h0000_0010, "R4 hold while run low");
    run_for(1'b0, 6, p, f);
    rd(1'b0, 32'h0000_000A, "R4 six steps");
    chk("R4 no pulse mid count", p, 0);

    // R5 one-shot
    run_for(1'b0, 15, p, f);
    chk("R5 one pulse", p, 1);
    chk("R5 pulse cycle", f, 10);
    rd(1'b0, 32'h0, "R5 parked at zero");

    // R6 reload mode
    wr(1'b0, 32'h8000_0004);
    rd(1'b0, 32'h8000_0004, "R3 mode bit readback");
    run_for(1'b0, 13, p, f);
    chk("R6 pulse count", p, 3);
    chk("R6 first pulse", f, 4);
    rd(1'b0, 32'h8000_0003, "R6 reloaded and stepping");

    // R7 write zero
    wr(1'b0, 32'h0);
    run_for(1'b0, 20, p, f);
    chk("R7 no pulse", p, 0);
    rd(1'b0, 32'h0, "R7 stays idle");

    // R8 write collides with final step
    wr(1'b0, 32'h0000_0003);
    run_for(1'b0, 2, p, f);
    @(negedge clk);
    run_en = 1'b1; stb_a = 1'b1; we = 1'b1; wdata = 32'h0000_0007;
    @(negedge clk);
    run_en = 1'b0; stb_a = 1'b0; we = 1'b0;
    chk("R8 no pulse on write", {31'b0, irq_a}, 32'h0);
    @(negedge clk);
    chk("R8 no late pulse", {31'b0, irq_a}, 32'h0);
    rd(1'b0, 32'h0000_0007, "R8 write won");

    // R9 watchdog variant
    wr(1'b1, 32'h8000_0003);
    rd(1'b1, 32'h0000_0003, "R9 mode bit dropped");
    run_for(1'b1, 8, p, f);
    chk("R9 single pulse", p, 1);
    chk("R9 pulse cycle", f, 3);
    rd(1'b1, 32'h0, "R9 stops at zero");

    repeat (2) @(negedge clk);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule